// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds eight binary semaphores that two independent agents, port A and port B, use to claim and hand back shared resources. Each port has its own select, read/write strobe, output enable, semaphore index, a single write-data bit and an eight-bit read bus. A port asks for a semaphore by writing 0 to it and gives it back by writing 1. It learns whether it holds the semaphore by reading it. The flags are active low: a reader sees 0 when it holds the semaphore and 1 otherwise.

Each semaphore keeps one request latch per port and a single owner state. A request made while the other port holds the semaphore is remembered. The moment the holder lets go, the waiting port becomes the holder, so the semaphore never passes through the free state. Requests that arrive in the same clock cycle are settled in favour of a fixed port, which a parameter selects. Read data is captured once at the start of each read and is held for as long as that read lasts.

All inputs are sampled on the rising clock edge. Reset is synchronous and active high. Control strobes are active low, except read/write, which is 1 for a read and 0 for a write.

Top module: `sem_bank_top`

## Requirements
- R1: After reset every semaphore is free and both read buses show 8'hFF.
- R2: The 3-bit index selects one of eight independent semaphores; an operation on one index never changes how any other index reads.
- R3: A write cycle (select low, read/write 0) with data 0 on a free semaphore makes the writing port its holder from the next cycle: that port reads 8'h00 and the other port reads 8'hFF.
- R4: Writes from the port that does not hold a semaphore never change its holder. A 0 from that port is latched as a pending request, and a 1 from that port withdraws any pending request.
- R5: When the holder writes 1 while the other port has a request pending, the other port becomes the holder from the next cycle and reads 8'h00.
- R6: When the holder writes 1 and no request is pending, the semaphore becomes free and both ports read 8'hFF.
- R7: If both ports request the same free semaphore in the same cycle, only the port named by TIE_PORT (0 = port A, 1 = port B) becomes the holder. An earlier request from either port always wins over a later one.
- R8: A read cycle (select low, read/write 1, output enable low) drives 8'h00 if the reader holds the addressed semaphore and 8'hFF otherwise. The value appears one cycle after the read starts and reflects the state before that edge. Outside a read the bus shows 8'hFF.
- R9: The read value captured at the start of a read stays unchanged for every following cycle in which the read conditions hold, even if the semaphore changes holder meanwhile. A fresh value is captured only after the read ends and a new read begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_sel_n | input | 1 | Port A semaphore select, active low |
| a_rw | input | 1 | Port A read/write, 1 = read, 0 = write |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_idx | input | 3 | Port A semaphore index |
| a_wd | input | 1 | Port A write data bit, 0 = request, 1 = release |
| a_rdata | output | 8 | Port A read data, flag on all bits |
| b_sel_n | input | 1 | Port B semaphore select, active low |
| b_rw | input | 1 | Port B read/write, 1 = read, 0 = write |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_idx | input | 3 | Port B semaphore index |
| b_wd | input | 1 | Port B write data bit, 0 = request, 1 = release |
| b_rdata | output | 8 | Port B read data, flag on all bits |

## Verification
The assertions check the following on every cycle:
- the state after reset;
- that a read bus only ever shows all zeros or all ones, and shows all ones when idle;
- that the read value stays frozen while a read lasts;
- that a holder keeps its semaphore until it writes 1 itself, whatever the other port does.

The bench's scenarios are needed for the rest:
- a latched pending request becoming ownership on release;
- a withdrawn request leaving the semaphore free;
- a same-cycle tie going to the configured port;
- semaphores at different indices staying independent;
- a frozen read that still shows the old value after a handover, until a new read picks up the new one.

// File: rtl/sem_bank_pkg.sv
package sem_bank_pkg;
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_A    = 2'd1,
    OWN_B    = 2'd2
  } owner_e;
endpackage

// File: rtl/sem_cell.sv
module sem_cell
  import sem_bank_pkg::*;
#(
  parameter bit TIE_TO_B = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_a,
  input  logic d_a,
  input  logic wr_b,
  input  logic d_b,
  output logic hold_a,
  output logic hold_b
);
  logic   pend_a_q, pend_b_q;
  logic   pend_a_nx, pend_b_nx;
  owner_e own_q, own_nx;

  // R4: a write from either port only updates that port's request latch
  assign pend_a_nx = wr_a ? ~d_a : pend_a_q;
  assign pend_b_nx = wr_b ? ~d_b : pend_b_q;

  always_comb begin
    own_nx = own_q;
    unique case (own_q)
      OWN_A: if (!pend_a_nx) own_nx = pend_b_nx ? OWN_B : OWN_NONE;  // R5 R6
      OWN_B: if (!pend_b_nx) own_nx = pend_a_nx ? OWN_A : OWN_NONE;  // R5 R6
      default: begin
        if (pend_a_nx && pend_b_nx) own_nx = TIE_TO_B ? OWN_B : OWN_A; // R7
        else if (pend_a_nx)         own_nx = OWN_A;                    // R3
        else if (pend_b_nx)         own_nx = OWN_B;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_a_q <= 1'b0;
      pend_b_q <= 1'b0;
      own_q    <= OWN_NONE;
    end else begin
      pend_a_q <= pend_a_nx;
      pend_b_q <= pend_b_nx;
      own_q    <= own_nx;
    end
  end

  assign hold_a = (own_q == OWN_A);
  assign hold_b = (own_q == OWN_B);
endmodule

// File: rtl/sem_port.sv
module sem_port #(
  parameter int NUM_SEM = 8,
  parameter int RD_W    = 8,
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel_n,
  input  logic               rw,
  input  logic               oe_n,
  input  logic [IDX_W-1:0]   idx,
  input  logic [NUM_SEM-1:0] held,
  output logic [NUM_SEM-1:0] wr_stb,
  output logic [RD_W-1:0]    rdata
);
  logic rd_on, rd_q, wr_on;

  assign rd_on = !sel_n && rw && !oe_n;
  assign wr_on = !sel_n && !rw;

  // R2: only the addressed semaphore sees the write strobe
  for (genvar g = 0; g < NUM_SEM; g++) begin : g_stb
    assign wr_stb[g] = wr_on && (idx == IDX_W'(g));
  end

  // R8 R9: capture on read start, hold while reading, all ones when idle
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q  <= 1'b0;
      rdata <= '1;
    end else begin
      rd_q <= rd_on;
      if (rd_on && !rd_q) rdata <= {RD_W{~held[idx]}};
      else if (!rd_on)    rdata <= '1;
    end
  end
endmodule

// File: rtl/sem_bank_top.sv
module sem_bank_top #(
  parameter int NUM_SEM  = 8,
  parameter int RD_W     = 8,
  parameter int TIE_PORT = 0,
  localparam int IDX_W   = $clog2(NUM_SEM)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             a_sel_n,
  input  logic             a_rw,
  input  logic             a_oe_n,
  input  logic [IDX_W-1:0] a_idx,
  input  logic             a_wd,
  output logic [RD_W-1:0]  a_rdata,
  input  logic             b_sel_n,
  input  logic             b_rw,
  input  logic             b_oe_n,
  input  logic [IDX_W-1:0] b_idx,
  input  logic             b_wd,
  output logic [RD_W-1:0]  b_rdata
);
  logic [NUM_SEM-1:0] held_a, held_b;
  logic [NUM_SEM-1:0] stb_a, stb_b;

  sem_port #(.NUM_SEM(NUM_SEM), .RD_W(RD_W)) port_a_i (
    .clk(clk), .rst(rst), .sel_n(a_sel_n), .rw(a_rw), .oe_n(a_oe_n),
    .idx(a_idx), .held(held_a), .wr_stb(stb_a), .rdata(a_rdata)
  );

  sem_port #(.NUM_SEM(NUM_SEM), .RD_W(RD_W)) port_b_i (
    .clk(clk), .rst(rst), .sel_n(b_sel_n), .rw(b_rw), .oe_n(b_oe_n),
    .idx(b_idx), .held(held_b), .wr_stb(stb_b), .rdata(b_rdata)
  );

  for (genvar s = 0; s < NUM_SEM; s++) begin : g_cell
    sem_cell #(.TIE_TO_B(TIE_PORT == 1)) cell_i (
      .clk(clk), .rst(rst),
      .wr_a(stb_a[s]), .d_a(a_wd),
      .wr_b(stb_b[s]), .d_b(b_wd),
      .hold_a(held_a[s]), .hold_b(held_b[s])
    );
  end
endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk #(
  parameter int NUM_SEM = 8,
  parameter int RD_W    = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               a_sel_n,
  input logic               a_rw,
  input logic               a_oe_n,
  input logic               a_wd,
  input logic [RD_W-1:0]    a_rdata,
  input logic               b_sel_n,
  input logic               b_rw,
  input logic               b_oe_n,
  input logic               b_wd,
  input logic [RD_W-1:0]    b_rdata,
  input logic [NUM_SEM-1:0] held_a,
  input logic [NUM_SEM-1:0] held_b,
  input logic [NUM_SEM-1:0] stb_a,
  input logic [NUM_SEM-1:0] stb_b
);
  logic rd_a, rd_b;
  assign rd_a = !a_sel_n && a_rw && !a_oe_n;
  assign rd_b = !b_sel_n && b_rw && !b_oe_n;

  // R1
  reset_free_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (held_a == '0 && held_b == '0 && a_rdata == '1 && b_rdata == '1));

  // R8
  idle_ones_a_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_a |=> a_rdata == '1);
  // R8
  idle_ones_b_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_b |=> b_rdata == '1);
  // R8
  shape_chk: assert property (@(posedge clk) disable iff (rst)
    (a_rdata == '0 || a_rdata == '1) && (b_rdata == '0 || b_rdata == '1));

  // R9
  freeze_a_chk: assert property (@(posedge clk) disable iff (rst)
    rd_a && $past(rd_a) |=> $stable(a_rdata));
  // R9
  freeze_b_chk: assert property (@(posedge clk) disable iff (rst)
    rd_b && $past(rd_b) |=> $stable(b_rdata));

  for (genvar s = 0; s < NUM_SEM; s++) begin : g_keep
    // R4
    keep_a_chk: assert property (@(posedge clk) disable iff (rst)
      held_a[s] && !(stb_a[s] && a_wd) |=> held_a[s]);
    // R4
    keep_b_chk: assert property (@(posedge clk) disable iff (rst)
      held_b[s] && !(stb_b[s] && b_wd) |=> held_b[s]);
  end
endmodule

bind sem_bank_top sem_bank_chk #(.NUM_SEM(NUM_SEM), .RD_W(RD_W)) chk_i (
  .clk(clk), .rst(rst),
  .a_sel_n(a_sel_n), .a_rw(a_rw), .a_oe_n(a_oe_n), .a_wd(a_wd), .a_rdata(a_rdata),
  .b_sel_n(b_sel_n), .b_rw(b_rw), .b_oe_n(b_oe_n), .b_wd(b_wd), .b_rdata(b_rdata),
  .held_a(held_a), .held_b(held_b), .stb_a(stb_a), .stb_b(stb_b)
);

// File: tb/sem_bank_top_tb_top.sv
module sem_bank_top_tb_top;
  localparam int TIE = 0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a_sel_n = 1'b1, a_rw = 1'b1, a_oe_n = 1'b1, a_wd = 1'b1;
  logic b_sel_n = 1'b1, b_rw = 1'b1, b_oe_n = 1'b1, b_wd = 1'b1;
  logic [2:0] a_idx = 3'd0, b_idx = 3'd0;
  logic [7:0] a_rdata, b_rdata;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  sem_bank_top #(.NUM_SEM(8), .RD_W(8), .TIE_PORT(TIE)) dut_i (
    .clk(clk), .rst(rst),
    .a_sel_n(a_sel_n), .a_rw(a_rw), .a_oe_n(a_oe_n), .a_idx(a_idx), .a_wd(a_wd), .a_rdata(a_rdata),
    .b_sel_n(b_sel_n), .b_rw(b_rw), .b_oe_n(b_oe_n), .b_idx(b_idx), .b_wd(b_wd), .b_rdata(b_rdata)
  );

  // behavioural reference: holder 0 free, 1 port A, 2 port B
  int holder [8];
  bit want_a [8];
  bit want_b [8];
  bit was_rd_a, was_rd_b;
  logic [7:0] exp_a = 8'hFF, exp_b = 8'hFF;

  always @(posedge clk) begin
    if (rst) begin
      foreach (holder[i]) begin holder[i] = 0; want_a[i] = 0; want_b[i] = 0; end
      was_rd_a = 0; was_rd_b = 0; exp_a = 8'hFF; exp_b = 8'hFF;
    end else begin
      bit ra, rb;
      ra = !a_sel_n && a_rw && !a_oe_n;
      rb = !b_sel_n && b_rw && !b_oe_n;
      if (!ra) exp_a = 8'hFF;
      else if (!was_rd_a) exp_a = (holder[a_idx] == 1) ? 8'h00 : 8'hFF;
      if (!rb) exp_b = 8'hFF;
      else if (!was_rd_b) exp_b = (holder[b_idx] == 2) ? 8'h00 : 8'hFF;
      was_rd_a = ra; was_rd_b = rb;
      if (!a_sel_n && !a_rw) want_a[a_idx] = !a_wd;
      if (!b_sel_n && !b_rw) want_b[b_idx] = !b_wd;
      foreach (holder[i]) begin
        if (holder[i] == 1 && !want_a[i]) holder[i] = want_b[i] ? 2 : 0;
        else if (holder[i] == 2 && !want_b[i]) holder[i] = want_a[i] ? 1 : 0;
        else if (holder[i] == 0) begin
          if (want_a[i] && want_b[i]) holder[i] = (TIE == 1) ? 2 : 1;
          else if (want_a[i]) holder[i] = 1;
          else if (want_b[i]) holder[i] = 2;
        end
      end
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      total += 2;
      if (a_rdata !== exp_a) begin
        bad++;
        $display("FAIL %s model a_rdata actual=%h expected=%h", cur_req, a_rdata, exp_a);
      end
      if (b_rdata !== exp_b) begin
        bad++;
        $display("FAIL %s model b_rdata actual=%h expected=%h", cur_req, b_rdata, exp_b);
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic idle_all();
    a_sel_n = 1; a_rw = 1; a_oe_n = 1; a_wd = 1;
    b_sel_n = 1; b_rw = 1; b_oe_n = 1; b_wd = 1;
  endtask

  task automatic wr(input bit port_b, input logic [2:0] i, input logic d);
    if (!port_b) begin a_sel_n = 0; a_rw = 0; a_idx = i; a_wd = d; end
    else         begin b_sel_n = 0; b_rw = 0; b_idx = i; b_wd = d; end
    cyc();
    idle_all();
  endtask

  // read one semaphore and return what the port shows after capture
  task automatic rd(input bit port_b, input logic [2:0] i, output logic [7:0] v);
    if (!port_b) begin a_sel_n = 0; a_rw = 1; a_oe_n = 0; a_idx = i; end
    else         begin b_sel_n = 0; b_rw = 1; b_oe_n = 0; b_idx = i; end
    cyc();
    v = port_b ? b_rdata : a_rdata;
    idle_all();
    cyc();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) cyc();
    rst = 0;
    cyc();
    cur_req = "R1";
    chk("R1 idle a", a_rdata, 8'hFF);
    chk("R1 idle b", b_rdata, 8'hFF);
    rd(0, 3'd6, v); chk("R1 free after reset", v, 8'hFF);

    cur_req = "R3";
    wr(0, 3'd2, 0);
    rd(0, 3'd2, v); chk("R3 holder reads 00", v, 8'h00);
    rd(1, 3'd2, v); chk("R3 other reads FF", v, 8'hFF);

    cur_req = "R4";
    wr(1, 3'd2, 0);
    rd(0, 3'd2, v); chk("R4 pending keeps holder", v, 8'h00);
    wr(1, 3'd2, 1);
    cur_req = "R6";
    wr(0, 3'd2, 1);
    rd(1, 3'd2, v); chk("R6 free b after withdraw", v, 8'hFF);
    rd(0, 3'd2, v); chk("R6 free a", v, 8'hFF);

    cur_req = "R5";
    wr(0, 3'd1, 0);
    wr(1, 3'd1, 0);
    wr(0, 3'd1, 1);
    rd(1, 3'd1, v); chk("R5 handover to b", v, 8'h00);
    rd(0, 3'd1, v); chk("R5 a released", v, 8'hFF);
    cur_req = "R4";
    wr(0, 3'd1, 1);
    rd(1, 3'd1, v); chk("R4 non-holder release ignored", v, 8'h00);

    cur_req = "R2";
    wr(0, 3'd5, 0);
    rd(0, 3'd6, v); chk("R2 neighbour untouched", v, 8'hFF);
    rd(0, 3'd5, v); chk("R2 addressed sem held", v, 8'h00);
    rd(1, 3'd1, v); chk("R2 other sem still b", v, 8'h00);

    cur_req = "R7";
    a_sel_n = 0; a_rw = 0; a_idx = 3'd3; a_wd = 0;
    b_sel_n = 0; b_rw = 0; b_idx = 3'd3; b_wd = 0;
    cyc(); idle_all();
    rd(0, 3'd3, v); chk("R7 tie to port a", v, 8'h00);
    rd(1, 3'd3, v); chk("R7 tie loser b", v, 8'hFF);
    wr(1, 3'd7, 0);
    wr(0, 3'd7, 0);
    rd(1, 3'd7, v); chk("R7 earlier b wins", v, 8'h00);

    cur_req = "R9";
    wr(1, 3'd4, 0);
    wr(0, 3'd4, 0);
    a_sel_n = 0; a_rw = 1; a_oe_n = 0; a_idx = 3'd4;
    cyc();
    chk("R9 captured FF", a_rdata, 8'hFF);
    b_sel_n = 0; b_rw = 0; b_idx = 3'd4; b_wd = 1;
    cyc();
    b_sel_n = 1; b_rw = 1; b_wd = 1;
    cyc();
    chk("R9 frozen after handover", a_rdata, 8'hFF);
    cyc();
    chk("R9 still frozen", a_rdata, 8'hFF);
    idle_all();
    cyc();
    chk("R8 idle after read", a_rdata, 8'hFF);
    cur_req = "R8";
    rd(0, 3'd4, v); chk("R9 new read sees ownership", v, 8'h00);
    rd(1, 3'd4, v); chk("R8 non-holder reads FF", v, 8'hFF);

    repeat (3) cyc();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule